// File: doc/BRIEF.md
# Macro-Instruction to Micro-op Cracker

This block takes one decoded macro-instruction at a time and breaks it into a short run of simple load/store-style micro-ops. It sends them out one per cycle on a valid/ready stream. Register-register operations, compares, branches and plain loads and stores pass through as a single micro-op. Forms that touch memory as an ALU operand, or that work on the stack (push, call, return), expand into fixed sequences of two to four micro-ops. These sequences route intermediate values through a temporary register that lies outside the architectural register range.

A front end drives a macro record on the input side whenever `in_ready` is high. The cracker stores that record and walks a step counter through its sequence. It stalls the step counter when the consumer holds `out_ready` low. The final micro-op of each sequence carries `out_last`. A new macro can be accepted in the same cycle that the final micro-op is taken.

Top module: `upc_cracker`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Macro classes ALU (in_cls 0) with in_mode 0, CMP (1), BR (2), LD (3) and ST (4) each yield exactly one micro-op, with out_last set. The fields are as follows. ALU gives op 1, fn=in_fn, rd=ra=dst, rb=src. CMP gives op 2, ra=dst, rb=src. BR gives op 3, fn=in_fn, imm=in_imm. LD gives op 4, rd=dst, ra=base, imm=in_imm. ST gives op 5, ra=base, rb=src, imm=in_imm. Every field not named is zero. Architectural register numbers are zero-extended to 5 bits.
- R3: An ALU macro with in_mode 1 (memory source) yields two micro-ops. The first is a load into temporary register 16 from base+imm. The second is the ALU op with rd=ra=dst and rb=16.
- R4: An ALU macro with in_mode 2 (memory destination) yields three micro-ops. The first is a load of 16 from base+imm. The second is the ALU op with rd=ra=16 and rb=src. The third is a store (op 5) with ra=base, rb=16 and imm=in_imm.
- R5: PUSH (in_cls 5) yields two micro-ops. The first is a store with ra=15 (stack pointer), rb=src and imm=16'hFFFC. The second is an add-immediate (op 6) with rd=ra=15 and imm=16'hFFFC.
- R6: CALL (in_cls 6) yields four micro-ops in this order. (a) A PC read (op 7) into rd=16. (b) A store with ra=15, rb=16 and imm=16'hFFFC. (c) An add-immediate with rd=ra=15 and imm=16'hFFFC. (d) A jump (op 8) with imm=in_imm.
- R7: RET (in_cls 7) yields three micro-ops in this order. (a) An add-immediate with rd=ra=15 and imm=16'h0004. (b) A load with rd=16, ra=15 and imm=16'hFFFC. (c) A register jump (op 9) with ra=16.
- R8: `out_last` is set only on the final micro-op of a sequence. `in_ready` is 0 while a micro-op that is not final is being presented. Every accepted macro's sequence is emitted in full, and in order of acceptance.
- R9: While `out_valid` is 1 and `out_ready` is 0, all output fields hold their values into the next cycle, and the sequence does not advance.
- R10: An in_cls value of 8 or above, or an ALU macro with in_mode 3, yields a single illegal micro-op (op 15) with all other fields zero and out_last set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Macro record offered |
| in_ready | output | 1 | Cracker can take a macro this cycle |
| in_cls | input | 4 | Macro class code |
| in_mode | input | 2 | ALU operand form: 0 reg, 1 memory source, 2 memory destination |
| in_fn | input | 3 | ALU function or branch condition |
| in_dst | input | 4 | Destination architectural register |
| in_src | input | 4 | Source architectural register |
| in_base | input | 4 | Base register of a memory operand |
| in_imm | input | 16 | Displacement, immediate or jump target |
| out_valid | output | 1 | Micro-op presented |
| out_ready | input | 1 | Consumer takes the micro-op this cycle |
| out_op | output | 4 | Micro-op code |
| out_fn | output | 3 | Function passed through for ALU and branch |
| out_rd | output | 5 | Destination register, including temporary 16 |
| out_ra | output | 5 | First source register |
| out_rb | output | 5 | Second source register |
| out_imm | output | 16 | Immediate of the micro-op |
| out_last | output | 1 | Final micro-op of the sequence |

## Verification
The bench goes after the handover between sequences. It offers a new macro in the very cycle that the final micro-op of the previous one is taken. A cracker that mishandled this would drop the new macro, or would restart the old sequence. It stalls the consumer in the middle of four-step calls and three-step memory-destination ALU ops. A design that advanced its step counter under stall would skip a micro-op or change fields while they are held. Directed cases cover ALU mode 3 and out-of-range classes. A decoder that treated those as ordinary forms would emit multi-step sequences, or would never raise the end marker.

// File: rtl/upc_pkg.sv
package upc_pkg;

    // Widths of the macro and micro-op records
    localparam int ARCH_W   = 4;
    localparam int UREG_W   = ARCH_W + 1;
    localparam int IMM_W    = 16;
    localparam int FN_W     = 3;
    localparam int CLS_W    = 4;
    localparam int MODE_W   = 2;
    localparam int MAX_UOPS = 4;
    localparam int STEP_W   = $clog2(MAX_UOPS);

    // Macro class codes
    localparam logic [CLS_W-1:0] MC_ALU  = CLS_W'(0);
    localparam logic [CLS_W-1:0] MC_CMP  = CLS_W'(1);
    localparam logic [CLS_W-1:0] MC_BR   = CLS_W'(2);
    localparam logic [CLS_W-1:0] MC_LD   = CLS_W'(3);
    localparam logic [CLS_W-1:0] MC_ST   = CLS_W'(4);
    localparam logic [CLS_W-1:0] MC_PUSH = CLS_W'(5);
    localparam logic [CLS_W-1:0] MC_CALL = CLS_W'(6);
    localparam logic [CLS_W-1:0] MC_RET  = CLS_W'(7);

    // ALU operand forms
    localparam logic [MODE_W-1:0] MD_REG  = MODE_W'(0);
    localparam logic [MODE_W-1:0] MD_MSRC = MODE_W'(1);
    localparam logic [MODE_W-1:0] MD_MDST = MODE_W'(2);

    typedef enum logic [3:0] {
        UO_NOP   = 4'd0,
        UO_ALU   = 4'd1,
        UO_CMP   = 4'd2,
        UO_BR    = 4'd3,
        UO_LD    = 4'd4,
        UO_ST    = 4'd5,
        UO_ADDI  = 4'd6,
        UO_GETPC = 4'd7,
        UO_JMP   = 4'd8,
        UO_JR    = 4'd9,
        UO_ILL   = 4'd15
    } uop_op_e;

    typedef struct packed {
        logic [CLS_W-1:0]  cls;
        logic [MODE_W-1:0] mode;
        logic [FN_W-1:0]   fn;
        logic [ARCH_W-1:0] dst;
        logic [ARCH_W-1:0] src;
        logic [ARCH_W-1:0] base;
        logic [IMM_W-1:0]  imm;
    } mac_t;

    typedef struct packed {
        uop_op_e           op;
        logic [FN_W-1:0]   fn;
        logic [UREG_W-1:0] rd;
        logic [UREG_W-1:0] ra;
        logic [UREG_W-1:0] rb;
        logic [IMM_W-1:0]  imm;
        logic              last;
    } uop_t;

endpackage

// File: rtl/upc_expand.sv
module upc_expand
    import upc_pkg::*;
#(
    parameter int SP_IDX  = 15,
    parameter int TMP_IDX = 16
) (
    input  mac_t              mac,
    input  logic [STEP_W-1:0] step,
    output uop_t              uop
);

    localparam logic [UREG_W-1:0] SP_R    = UREG_W'(SP_IDX);
    localparam logic [UREG_W-1:0] TMP_R   = UREG_W'(TMP_IDX);
    localparam logic [IMM_W-1:0]  STK_DN  = IMM_W'(-4);
    localparam logic [IMM_W-1:0]  STK_UP  = IMM_W'(4);
    localparam logic [STEP_W-1:0] S0      = STEP_W'(0);
    localparam logic [STEP_W-1:0] S1      = STEP_W'(1);
    localparam logic [STEP_W-1:0] S2      = STEP_W'(2);

    function automatic logic [UREG_W-1:0] ar(input logic [ARCH_W-1:0] r);
        return {1'b0, r};
    endfunction

    function automatic uop_t mk(
        input uop_op_e           op,
        input logic [FN_W-1:0]   fn,
        input logic [UREG_W-1:0] rd,
        input logic [UREG_W-1:0] ra,
        input logic [UREG_W-1:0] rb,
        input logic [IMM_W-1:0]  imm,
        input logic              last
    );
        uop_t u;
        u.op   = op;
        u.fn   = fn;
        u.rd   = rd;
        u.ra   = ra;
        u.rb   = rb;
        u.imm  = imm;
        u.last = last;
        return u;
    endfunction

    localparam logic [UREG_W-1:0] RZ = '0;
    localparam logic [IMM_W-1:0]  IZ = '0;
    localparam logic [FN_W-1:0]   FZ = '0;

    uop_t illegal_u;
    assign illegal_u = mk(UO_ILL, FZ, RZ, RZ, RZ, IZ, 1'b1);

    always_comb begin
        uop = illegal_u;
        case (mac.cls)
            MC_ALU: begin
                case (mac.mode)
                    MD_REG: uop = mk(UO_ALU, mac.fn, ar(mac.dst), ar(mac.dst),
                                     ar(mac.src), IZ, 1'b1);
                    MD_MSRC: begin
                        if (step == S0)
                            uop = mk(UO_LD, FZ, TMP_R, ar(mac.base), RZ, mac.imm, 1'b0);
                        else
                            uop = mk(UO_ALU, mac.fn, ar(mac.dst), ar(mac.dst),
                                     TMP_R, IZ, 1'b1);
                    end
                    MD_MDST: begin
                        case (step)
                            S0:      uop = mk(UO_LD, FZ, TMP_R, ar(mac.base), RZ,
                                              mac.imm, 1'b0);
                            S1:      uop = mk(UO_ALU, mac.fn, TMP_R, TMP_R,
                                              ar(mac.src), IZ, 1'b0);
                            default: uop = mk(UO_ST, FZ, RZ, ar(mac.base), TMP_R,
                                              mac.imm, 1'b1);
                        endcase
                    end
                    default: uop = illegal_u;
                endcase
            end
            MC_CMP:  uop = mk(UO_CMP, FZ, RZ, ar(mac.dst), ar(mac.src), IZ, 1'b1);
            MC_BR:   uop = mk(UO_BR, mac.fn, RZ, RZ, RZ, mac.imm, 1'b1);
            MC_LD:   uop = mk(UO_LD, FZ, ar(mac.dst), ar(mac.base), RZ, mac.imm, 1'b1);
            MC_ST:   uop = mk(UO_ST, FZ, RZ, ar(mac.base), ar(mac.src), mac.imm, 1'b1);
            MC_PUSH: begin
                if (step == S0)
                    uop = mk(UO_ST, FZ, RZ, SP_R, ar(mac.src), STK_DN, 1'b0);
                else
                    uop = mk(UO_ADDI, FZ, SP_R, SP_R, RZ, STK_DN, 1'b1);
            end
            MC_CALL: begin
                case (step)
                    S0:      uop = mk(UO_GETPC, FZ, TMP_R, RZ, RZ, IZ, 1'b0);
                    S1:      uop = mk(UO_ST, FZ, RZ, SP_R, TMP_R, STK_DN, 1'b0);
                    S2:      uop = mk(UO_ADDI, FZ, SP_R, SP_R, RZ, STK_DN, 1'b0);
                    default: uop = mk(UO_JMP, FZ, RZ, RZ, RZ, mac.imm, 1'b1);
                endcase
            end
            MC_RET: begin
                case (step)
                    S0:      uop = mk(UO_ADDI, FZ, SP_R, SP_R, RZ, STK_UP, 1'b0);
                    S1:      uop = mk(UO_LD, FZ, TMP_R, SP_R, RZ, STK_DN, 1'b0);
                    default: uop = mk(UO_JR, FZ, RZ, TMP_R, RZ, IZ, 1'b1);
                endcase
            end
            default: uop = illegal_u;
        endcase
    end

endmodule

// File: rtl/upc_ctrl.sv
module upc_ctrl
    import upc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  mac_t              mac_in,
    input  logic              out_ready,
    input  logic              last,
    output logic              in_ready,
    output logic              busy,
    output mac_t              mac_q,
    output logic [STEP_W-1:0] step_q
);

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        mac_t              mac;
    } ctl_t;

    ctl_t st_d;
    ctl_t st_q;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.busy || (out_ready && last);
        if (in_valid && in_ready) begin
            st_d.busy = 1'b1;
            st_d.step = '0;
            st_d.mac  = mac_in;
        end else if (st_q.busy && out_ready) begin
            if (last) begin
                st_d.busy = 1'b0;
                st_d.step = '0;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign mac_q  = st_q.mac;
    assign step_q = st_q.step;

endmodule

// File: rtl/upc_cracker.sv
module upc_cracker
    import upc_pkg::*;
#(
    parameter int SP_IDX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CLS_W-1:0]  in_cls,
    input  logic [MODE_W-1:0] in_mode,
    input  logic [FN_W-1:0]   in_fn,
    input  logic [ARCH_W-1:0] in_dst,
    input  logic [ARCH_W-1:0] in_src,
    input  logic [ARCH_W-1:0] in_base,
    input  logic [IMM_W-1:0]  in_imm,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3:0]        out_op,
    output logic [FN_W-1:0]   out_fn,
    output logic [UREG_W-1:0] out_rd,
    output logic [UREG_W-1:0] out_ra,
    output logic [UREG_W-1:0] out_rb,
    output logic [IMM_W-1:0]  out_imm,
    output logic              out_last
);

    // First register number past the architectural range
    localparam int TMP_IDX = 1 << ARCH_W;

    mac_t              mac_in;
    mac_t              mac_q;
    logic [STEP_W-1:0] step_q;
    logic              busy;
    uop_t              uop;

    assign mac_in = '{cls: in_cls, mode: in_mode, fn: in_fn, dst: in_dst,
                      src: in_src, base: in_base, imm: in_imm};

    upc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mac_in    (mac_in),
        .out_ready (out_ready),
        .last      (uop.last),
        .in_ready  (in_ready),
        .busy      (busy),
        .mac_q     (mac_q),
        .step_q    (step_q)
    );

    upc_expand #(
        .SP_IDX  (SP_IDX),
        .TMP_IDX (TMP_IDX)
    ) u_expand (
        .mac  (mac_q),
        .step (step_q),
        .uop  (uop)
    );

    assign out_valid = busy;
    assign out_op    = uop.op;
    assign out_fn    = uop.fn;
    assign out_rd    = uop.rd;
    assign out_ra    = uop.ra;
    assign out_rb    = uop.rb;
    assign out_imm   = uop.imm;
    assign out_last  = uop.last;

endmodule

// File: rtl/upc_cracker_chk.sv
module upc_cracker_chk
    import upc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [3:0]        out_op,
    input logic [FN_W-1:0]   out_fn,
    input logic [UREG_W-1:0] out_rd,
    input logic [UREG_W-1:0] out_ra,
    input logic [UREG_W-1:0] out_rb,
    input logic [IMM_W-1:0]  out_imm,
    input logic              out_last
);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_fn)
            && $stable(out_rd) && $stable(out_ra) && $stable(out_rb)
            && $stable(out_imm) && $stable(out_last)));

    assert_no_take_midseq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready);

    assert_illegal_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_op == UO_ILL) |-> out_last);

    assert_simple_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_op == UO_CMP || out_op == UO_BR)) |-> out_last);

    assert_getpc_then_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_op == UO_GETPC) |=> (out_valid && out_op == UO_ST));

    assert_jr_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_op == UO_JR) |-> out_last);

endmodule

bind upc_cracker upc_cracker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_op    (out_op),
    .out_fn    (out_fn),
    .out_rd    (out_rd),
    .out_ra    (out_ra),
    .out_rb    (out_rb),
    .out_imm   (out_imm),
    .out_last  (out_last)
);

// File: tb/upc_cracker_bench.sv
`timescale 1ns/100ps
module upc_cracker_bench;

    localparam int UW     = 39;
    localparam int NMAC   = 500;
    localparam int NDIR   = 13;
    localparam logic [4:0]  T0 = 5'd16;
    localparam logic [4:0]  SP = 5'd15;
    localparam logic [4:0]  Z5 = 5'd0;
    localparam logic [15:0] DN = 16'hFFFC;
    localparam logic [15:0] UP = 16'h0004;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, in_valid, in_ready, out_valid, out_ready, out_last;
    logic [3:0]  in_cls, in_dst, in_src, in_base, out_op;
    logic [1:0]  in_mode;
    logic [2:0]  in_fn, out_fn;
    logic [15:0] in_imm, out_imm;
    logic [4:0]  out_rd, out_ra, out_rb;
    logic [UW-1:0] got;

    upc_cracker u_upc_cracker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_mode(in_mode), .in_fn(in_fn), .in_dst(in_dst),
        .in_src(in_src), .in_base(in_base), .in_imm(in_imm),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
        .out_fn(out_fn), .out_rd(out_rd), .out_ra(out_ra), .out_rb(out_rb),
        .out_imm(out_imm), .out_last(out_last)
    );

    assign got = {out_op, out_fn, out_rd, out_ra, out_rb, out_imm, out_last};

    int errors = 0;
    int checks = 0;
    logic [UW-1:0] exp_q[$];
    int            req_q[$];

    function automatic string rname(input int r);
        case (r)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [UW-1:0] act, input logic [UW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [UW-1:0] mk(input logic [3:0] op, input logic [2:0] f,
            input logic [4:0] rd, input logic [4:0] ra, input logic [4:0] rb,
            input logic [15:0] im, input logic l);
        return {op, f, rd, ra, rb, im, l};
    endfunction

    task automatic put(input logic [UW-1:0] v, input int r);
        exp_q.push_back(v);
        req_q.push_back(r);
    endtask

    // Expected sequence of each macro form, written from the requirements
    task automatic exp_push(input logic [3:0] c, input logic [1:0] m, input logic [2:0] f,
                            input logic [3:0] d, input logic [3:0] s, input logic [3:0] b,
                            input logic [15:0] im);
        logic [4:0] dd;
        logic [4:0] ss;
        logic [4:0] bb;
        dd = {1'b0, d};
        ss = {1'b0, s};
        bb = {1'b0, b};
        case (c)
            4'd0: case (m)
                2'd0: put(mk(4'd1, f, dd, dd, ss, 16'd0, 1'b1), 2);
                2'd1: begin                                        // R3
                    put(mk(4'd4, 3'd0, T0, bb, Z5, im, 1'b0), 3);
                    put(mk(4'd1, f, dd, dd, T0, 16'd0, 1'b1), 3);
                end
                2'd2: begin                                        // R4
                    put(mk(4'd4, 3'd0, T0, bb, Z5, im, 1'b0), 4);
                    put(mk(4'd1, f, T0, T0, ss, 16'd0, 1'b0), 4);
                    put(mk(4'd5, 3'd0, Z5, bb, T0, im, 1'b1), 4);
                end
                default: put(mk(4'd15, 3'd0, Z5, Z5, Z5, 16'd0, 1'b1), 10);
            endcase
            4'd1: put(mk(4'd2, 3'd0, Z5, dd, ss, 16'd0, 1'b1), 2);
            4'd2: put(mk(4'd3, f, Z5, Z5, Z5, im, 1'b1), 2);
            4'd3: put(mk(4'd4, 3'd0, dd, bb, Z5, im, 1'b1), 2);
            4'd4: put(mk(4'd5, 3'd0, Z5, bb, ss, im, 1'b1), 2);
            4'd5: begin                                            // R5
                put(mk(4'd5, 3'd0, Z5, SP, ss, DN, 1'b0), 5);
                put(mk(4'd6, 3'd0, SP, SP, Z5, DN, 1'b1), 5);
            end
            4'd6: begin                                            // R6
                put(mk(4'd7, 3'd0, T0, Z5, Z5, 16'd0, 1'b0), 6);
                put(mk(4'd5, 3'd0, Z5, SP, T0, DN, 1'b0), 6);
                put(mk(4'd6, 3'd0, SP, SP, Z5, DN, 1'b0), 6);
                put(mk(4'd8, 3'd0, Z5, Z5, Z5, im, 1'b1), 6);
            end
            4'd7: begin                                            // R7
                put(mk(4'd6, 3'd0, SP, SP, Z5, UP, 1'b0), 7);
                put(mk(4'd4, 3'd0, T0, SP, Z5, DN, 1'b0), 7);
                put(mk(4'd9, 3'd0, Z5, T0, Z5, 16'd0, 1'b1), 7);
            end
            default: put(mk(4'd15, 3'd0, Z5, Z5, Z5, 16'd0, 1'b1), 10);
        endcase
    endtask

    task automatic load_macro(input int idx);
        in_fn   = 3'($urandom_range(0, 7));
        in_dst  = 4'($urandom_range(0, 15));
        in_src  = 4'($urandom_range(0, 15));
        in_base = 4'($urandom_range(0, 15));
        in_imm  = 16'($urandom_range(0, 65535));
        in_mode = 2'd0;
        case (idx)
            0:  in_cls = 4'd0;
            1:  in_cls = 4'd1;
            2:  in_cls = 4'd2;
            3:  in_cls = 4'd3;
            4:  in_cls = 4'd4;
            5:  begin in_cls = 4'd0; in_mode = 2'd1; end
            6:  begin in_cls = 4'd0; in_mode = 2'd2; end
            7:  in_cls = 4'd5;
            8:  in_cls = 4'd6;
            9:  in_cls = 4'd7;
            10: begin in_cls = 4'd0; in_mode = 2'd3; end    // R10 illegal mode
            11: in_cls = 4'd8;                              // R10 first illegal class
            12: in_cls = 4'd15;                             // R10 top class code
            default: begin
                in_cls  = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(8, 15))
                                                      : 4'($urandom_range(0, 7));
                in_mode = 2'($urandom_range(0, 3));
            end
        endcase
    endtask

    bit            hold_pend;
    logic [UW-1:0] held;
    bit            pend;
    int            sent;

    task automatic cycle(input bit rnd);
        @(negedge clk);
        if (hold_pend)
            chk(out_valid === 1'b1 && got === held, "R9 held under stall", got, held);
        if (!pend && sent < NMAC) begin
            load_macro(sent);
            pend = 1'b1;
        end
        in_valid  = pend && (!rnd || $urandom_range(0, 4) != 0);
        out_ready = !rnd || ($urandom_range(0, 2) != 0);
        #1;
        if (out_valid && !out_last)
            chk(in_ready === 1'b0, "R8 in_ready low mid-sequence", {38'd0, in_ready}, '0);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected micro-op", got, '0);
            end else begin
                logic [UW-1:0] e;
                int r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(got === e, rname(r), got, e);
            end
        end
        hold_pend = out_valid && !out_ready;
        held      = got;
        if (in_valid && in_ready) begin
            exp_push(in_cls, in_mode, in_fn, in_dst, in_src, in_base, in_imm);
            pend = 1'b0;
            sent++;
        end
    endtask

    initial begin
        void'($urandom(32'h1D5EED));
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_cls = '0; in_mode = '0; in_fn = '0; in_dst = '0; in_src = '0;
        in_base = '0; in_imm = '0;
        hold_pend = 1'b0; pend = 1'b0; sent = 0; held = '0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 during reset",
            {37'd0, out_valid, in_ready}, {37'd0, 2'b01});
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 after release",
            {37'd0, out_valid, in_ready}, {37'd0, 2'b01});
        // directed forms with a consumer that never stalls
        while (sent < NDIR) cycle(1'b0);
        // random mix with stalls and input gaps
        while (sent < NMAC) cycle(1'b1);
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) cycle(1'b1);
        chk(exp_q.size() == 0, "R8 all sequences drained",
            UW'(exp_q.size()), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule